// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand field of a 16-bit instruction word into an operand reference. The reference can take four forms. It can name a register. It can give a memory word address. It can carry a short constant. It can ask the sequencer to consume the instruction word that follows. The block also works out the new stack pointer and program counter that the chosen mode implies, and whether the mode costs an extra cycle.

The caller presents the field code together with the eight general register values, the current SP and PC, and the memory word at PC. The block drives that memory read address itself. On a cycle with the decode enable high, the result is captured into output registers and appears one clock later. The caller then performs the operand access and commits the new SP and PC. Small constants are held in an auxiliary register that keeps the last constant decoded. Instruction sequencing and arithmetic are left to the surrounding logic.

Top module: `opnd_decode`

## Requirements
- R1: While reset is asserted, all registered outputs read zero and `res_valid` is low.
- R2: Codes 0x00 to 0x07 give kind 0 (register) with `res_ridx` equal to the code, SP and PC unchanged, no extra cycle, writable.
- R3: Codes 0x08 to 0x0F give kind 1 (memory) with the address taken from general register (code minus 8), SP and PC unchanged, no extra cycle.
- R4: Codes 0x10 to 0x17 give kind 1 with the address equal to the next word plus general register (code minus 0x10), modulo 2^16. PC advances by one and the extra-cycle flag is set.
- R5: Code 0x18 addresses memory at SP and advances SP by one. Code 0x19 addresses memory at SP and leaves SP alone. Code 0x1A lowers SP by one and addresses memory at the lowered value. None of these three touches PC or sets the extra flag.
- R6: Codes 0x1B, 0x1C and 0x1D give kind 0 with `res_ridx` 8 (SP), 9 (PC) and 10 (overflow) respectively.
- R7: Code 0x1E gives kind 1 addressed by the next word. Code 0x1F gives kind 3 (next word as operand) with the address equal to the old PC. Both advance PC by one and set the extra flag.
- R8: Codes 0x20 to 0x3F give kind 2 with `res_lit` equal to the code minus 0x20, and `res_writable` low. `res_lit` keeps its last constant across the other codes.
- R9: Every SP and PC step wraps modulo 2^16, so 0xFFFF+1 is 0 and 0-1 is 0xFFFF.
- R10: Results appear on the clock after an enabled cycle with `res_valid` high. After a cycle with the enable low, `res_valid` is low and every result holds its value.
- R11: `nw_addr` follows `pc_cur` with no clock delay.
- R12: For kinds other than memory and next-word, `res_addr` is zero. For kinds other than register, `res_ridx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Capture a decode this cycle |
| code | input | 6 | Operand field code |
| gpr_flat | input | 128 | Eight general registers, register i at bits 16i+15:16i |
| sp_cur | input | 16 | Current stack pointer |
| pc_cur | input | 16 | Current program counter, pointing at the next word |
| nw_data | input | 16 | Memory word read at `nw_addr` |
| nw_addr | output | 16 | Read address for the next word |
| res_valid | output | 1 | Result registers were loaded on the last clock |
| res_kind | output | 2 | 0 register, 1 memory, 2 constant, 3 next word |
| res_ridx | output | 4 | Register index: 0-7 general, 8 SP, 9 PC, 10 overflow |
| res_addr | output | 16 | Memory word address |
| res_lit | output | 16 | Auxiliary constant register |
| res_writable | output | 1 | Operand accepts writes |
| res_sp | output | 16 | Stack pointer after the operand's side effect |
| res_pc | output | 16 | Program counter after the operand's side effect |
| res_extra | output | 1 | The mode costs one extra cycle |

## Verification
The assertions check several rules on every cycle. A constant result is never writable. The extra-cycle flag appears exactly when PC moved. SP moves by at most one step. Register indices stay in range, and results hold while the enable is low. What the assertions cannot show is whether each code lands on the right mode and address. The bench covers that by sweeping all 64 codes under register, SP, PC and next-word patterns chosen to hit the wrap points, including the retained constant and the index-plus-offset carry.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned NGPR   = 8;
  localparam int unsigned GSEL_W = $clog2(NGPR);
  localparam int unsigned RIDX_W = 4;
  localparam logic [RIDX_W-1:0] RIDX_SP  = 4'd8;
  localparam logic [RIDX_W-1:0] RIDX_PC  = 4'd9;
  localparam logic [RIDX_W-1:0] RIDX_OVF = 4'd10;

  typedef enum logic [1:0] {
    K_REG = 2'd0,
    K_MEM = 2'd1,
    K_LIT = 2'd2,
    K_NXT = 2'd3
  } opnd_kind_e;

  typedef enum logic [3:0] {
    M_GPR, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
    M_SP, M_PC, M_OVF, M_NWIND, M_NWIMM, M_LIT
  } opnd_mode_e;
endpackage

// File: rtl/opnd_classify.sv
module opnd_classify
  import opnd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output opnd_mode_e        mode,
  output logic [GSEL_W-1:0] gsel
);
  always_comb begin
    gsel = code[GSEL_W-1:0];
    mode = M_GPR;
    if (code[5]) begin
      mode = M_LIT;
    end else begin
      unique case (code[4:3])
        2'd0: mode = M_GPR;
        2'd1: mode = M_IND;
        2'd2: mode = M_IDX;
        default: begin
          unique case (code[2:0])
            3'd0: mode = M_POP;
            3'd1: mode = M_PEEK;
            3'd2: mode = M_PUSH;
            3'd3: mode = M_SP;
            3'd4: mode = M_PC;
            3'd5: mode = M_OVF;
            3'd6: mode = M_NWIND;
            default: mode = M_NWIMM;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_eagen.sv
module opnd_eagen
  import opnd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  opnd_mode_e         mode,
  input  logic [GSEL_W-1:0]  gsel,
  input  logic [NGPR*DW-1:0] gpr_flat,
  input  logic [DW-1:0]      sp_cur,
  input  logic [DW-1:0]      pc_cur,
  input  logic [DW-1:0]      nw_data,
  output opnd_kind_e         kind,
  output logic [RIDX_W-1:0]  ridx,
  output logic [DW-1:0]      addr,
  output logic [DW-1:0]      sp_nxt,
  output logic [DW-1:0]      pc_nxt,
  output logic               extra,
  output logic               writable
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] gval;
  logic [DW-1:0] sp_dec;
  logic [DW-1:0] pc_inc;

  assign gval   = gpr_flat[int'(gsel)*DW +: DW];
  assign sp_dec = sp_cur - ONE;
  assign pc_inc = pc_cur + ONE;

  always_comb begin
    kind     = K_MEM;
    ridx     = '0;
    addr     = '0;
    sp_nxt   = sp_cur;
    pc_nxt   = pc_cur;
    extra    = 1'b0;
    writable = 1'b1;
    unique case (mode)
      M_GPR: begin
        kind = K_REG;
        ridx = RIDX_W'(gsel);
      end
      M_IND:  addr = gval;
      M_IDX: begin
        addr   = nw_data + gval;
        pc_nxt = pc_inc;
        extra  = 1'b1;
      end
      M_POP: begin
        addr   = sp_cur;
        sp_nxt = sp_cur + ONE;
      end
      M_PEEK: addr = sp_cur;
      M_PUSH: begin
        addr   = sp_dec;
        sp_nxt = sp_dec;
      end
      M_SP: begin
        kind = K_REG;
        ridx = RIDX_SP;
      end
      M_PC: begin
        kind = K_REG;
        ridx = RIDX_PC;
      end
      M_OVF: begin
        kind = K_REG;
        ridx = RIDX_OVF;
      end
      M_NWIND: begin
        addr   = nw_data;
        pc_nxt = pc_inc;
        extra  = 1'b1;
      end
      M_NWIMM: begin
        kind   = K_NXT;
        addr   = pc_cur;
        pc_nxt = pc_inc;
        extra  = 1'b1;
      end
      default: begin
        kind     = K_LIT;
        writable = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_en,
  input  logic [CODE_W-1:0]    code,
  input  logic [NGPR*DW-1:0]   gpr_flat,
  input  logic [DW-1:0]        sp_cur,
  input  logic [DW-1:0]        pc_cur,
  input  logic [DW-1:0]        nw_data,
  output logic [DW-1:0]        nw_addr,
  output logic                 res_valid,
  output logic [1:0]           res_kind,
  output logic [RIDX_W-1:0]    res_ridx,
  output logic [DW-1:0]        res_addr,
  output logic [DW-1:0]        res_lit,
  output logic                 res_writable,
  output logic [DW-1:0]        res_sp,
  output logic [DW-1:0]        res_pc,
  output logic                 res_extra
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  opnd_mode_e        mode;
  logic [GSEL_W-1:0] gsel;
  opnd_kind_e        kind_c;
  logic [RIDX_W-1:0] ridx_c;
  logic [DW-1:0]     addr_c, sp_c, pc_c;
  logic              extra_c, wr_c;

  opnd_classify u_cls (.code(code), .mode(mode), .gsel(gsel));

  opnd_eagen #(.DW(DW)) u_ea (
    .mode(mode), .gsel(gsel), .gpr_flat(gpr_flat),
    .sp_cur(sp_cur), .pc_cur(pc_cur), .nw_data(nw_data),
    .kind(kind_c), .ridx(ridx_c), .addr(addr_c),
    .sp_nxt(sp_c), .pc_nxt(pc_c), .extra(extra_c), .writable(wr_c)
  );

  assign nw_addr = pc_cur;

  logic [1:0]        kind_d;
  logic [RIDX_W-1:0] ridx_d;
  logic [DW-1:0]     addr_d, lit_d, sp_d, pc_d;
  logic              wr_d, extra_d;

  always_comb begin
    kind_d  = res_kind;
    ridx_d  = res_ridx;
    addr_d  = res_addr;
    lit_d   = res_lit;
    sp_d    = res_sp;
    pc_d    = res_pc;
    wr_d    = res_writable;
    extra_d = res_extra;
    if (dec_en) begin
      kind_d  = kind_c;
      ridx_d  = ridx_c;
      addr_d  = addr_c;
      sp_d    = sp_c;
      pc_d    = pc_c;
      wr_d    = wr_c;
      extra_d = extra_c;
      if (mode == M_LIT) lit_d = DW'(code[CODE_W-2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_kind     <= '0;
      res_ridx     <= '0;
      res_addr     <= '0;
      res_lit      <= '0;
      res_sp       <= '0;
      res_pc       <= '0;
      res_writable <= 1'b0;
      res_extra    <= 1'b0;
    end else if (rst_q) begin
      res_valid    <= dec_en;
      res_kind     <= kind_d;
      res_ridx     <= ridx_d;
      res_addr     <= addr_d;
      res_lit      <= lit_d;
      res_sp       <= sp_d;
      res_pc       <= pc_d;
      res_writable <= wr_d;
      res_extra    <= extra_d;
    end
  end

  // R8: constants never accept a write
  p_lit_ro_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && res_kind == 2'd2) |-> !res_writable);

  // R7 / R4: extra cycle exactly when PC was consumed
  p_extra_pc_r7: assert property (@(posedge clk) disable iff (!rst_q)
    res_valid |-> (res_extra == (res_pc != $past(pc_cur))));

  // R5: SP moves by at most one step
  p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_q)
    res_valid |-> (res_sp == $past(sp_cur) || res_sp == $past(sp_cur) + DW'(1)
                   || res_sp == $past(sp_cur) - DW'(1)));

  // R6: register index stays in the defined range
  p_ridx_rng_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && res_kind == 2'd0) |-> (res_ridx <= RIDX_OVF));

  // R10: results hold after an idle cycle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (rst_q && !dec_en) |=> (!res_valid && $stable(res_addr) && $stable(res_sp)
                            && $stable(res_pc) && $stable(res_lit)));
endmodule

// File: tb/opnd_decode_test.sv
module opnd_decode_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         dec_en;
  logic [5:0]   code;
  logic [127:0] gpr_flat;
  logic [15:0]  sp_cur, pc_cur, nw_data;
  logic [15:0]  nw_addr, res_addr, res_lit, res_sp, res_pc;
  logic         res_valid, res_writable, res_extra;
  logic [1:0]   res_kind;
  logic [3:0]   res_ridx;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_lit = 16'h0;

  always #2.5 clk = ~clk;

  opnd_decode uut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .code(code),
    .gpr_flat(gpr_flat), .sp_cur(sp_cur), .pc_cur(pc_cur), .nw_data(nw_data),
    .nw_addr(nw_addr), .res_valid(res_valid), .res_kind(res_kind),
    .res_ridx(res_ridx), .res_addr(res_addr), .res_lit(res_lit),
    .res_writable(res_writable), .res_sp(res_sp), .res_pc(res_pc),
    .res_extra(res_extra)
  );

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] g(input int i);
    return gpr_flat[i*16 +: 16];
  endfunction

  function automatic string tag(input logic [5:0] c);
    if (c < 6'h08) return "R2";
    if (c < 6'h10) return "R3";
    if (c < 6'h18) return "R4";
    if (c < 6'h1b) return "R5";
    if (c < 6'h1e) return "R6";
    if (c < 6'h20) return "R7";
    return "R8";
  endfunction

  task automatic cmp(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s code=%02h: got %04h expected %04h", req, what, code, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] c);
    logic [1:0]  ek;
    logic [3:0]  er;
    logic [15:0] ea, es, ep;
    logic        ew, ex;
    int r;
    r  = int'(c[2:0]);
    ek = 2'd1; er = 4'd0; ea = 16'h0; es = sp_cur; ep = pc_cur; ew = 1'b1; ex = 1'b0;
    if (c >= 6'h20) begin ek = 2'd2; ew = 1'b0; last_lit = 16'(c - 6'h20); end
    else if (c < 6'h08) begin ek = 2'd0; er = 4'(c); end
    else if (c < 6'h10) ea = g(r);
    else if (c < 6'h18) begin ea = 16'((32'(nw_data) + 32'(g(r))) & 32'hFFFF); ep = pc_cur + 16'd1; ex = 1'b1; end
    else case (c)
      6'h18: begin ea = sp_cur; es = sp_cur + 16'd1; end
      6'h19: ea = sp_cur;
      6'h1a: begin ea = sp_cur - 16'd1; es = ea; end
      6'h1b: begin ek = 2'd0; er = 4'd8; end
      6'h1c: begin ek = 2'd0; er = 4'd9; end
      6'h1d: begin ek = 2'd0; er = 4'd10; end
      6'h1e: begin ea = nw_data; ep = pc_cur + 16'd1; ex = 1'b1; end
      default: begin ek = 2'd3; ea = pc_cur; ep = pc_cur + 16'd1; ex = 1'b1; end
    endcase
    code = c; dec_en = 1'b1;
    #1;
    cmp("R11", "nw_addr", nw_addr, pc_cur);
    @(negedge clk);
    cmp("R10", "valid", 16'(res_valid), 16'd1);
    cmp(tag(c), "kind", 16'(res_kind), 16'(ek));
    cmp((ek == 2'd0) ? tag(c) : "R12", "ridx", 16'(res_ridx), 16'(er));
    cmp((ek == 2'd1 || ek == 2'd3) ? tag(c) : "R12", "addr", res_addr, ea);
    cmp((c inside {6'h18, 6'h1a}) ? "R9" : tag(c), "sp", res_sp, es);
    cmp(ex ? "R9" : tag(c), "pc", res_pc, ep);
    cmp(tag(c), "writable", 16'(res_writable), 16'(ew));
    cmp(tag(c), "extra", 16'(res_extra), 16'(ex));
    cmp("R8", "lit", res_lit, last_lit);
    dec_en = 1'b0;
  endtask

  task automatic set_pat(input int p);
    for (int i = 0; i < 8; i++) begin
      case (p)
        0: gpr_flat[i*16 +: 16] = 16'(16'h1000 + i * 16'h0111);
        1: gpr_flat[i*16 +: 16] = 16'(16'hFFFF - i);
        2: gpr_flat[i*16 +: 16] = 16'(i * 16'h2468);
        default: gpr_flat[i*16 +: 16] = 16'h0;
      endcase
    end
    case (p)
      0: begin sp_cur = 16'h8000; pc_cur = 16'h0100; nw_data = 16'h0020; end
      1: begin sp_cur = 16'h0000; pc_cur = 16'hFFFF; nw_data = 16'hFFF0; end
      2: begin sp_cur = 16'hFFFF; pc_cur = 16'h7FFF; nw_data = 16'h1234; end
      default: begin sp_cur = 16'h0001; pc_cur = 16'h0000; nw_data = 16'h0000; end
    endcase
  endtask

  initial begin
    logic [15:0] h_addr, h_sp, h_pc, h_lit;
    rst_n = 1'b0; dec_en = 1'b0; code = 6'h00;
    set_pat(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "valid", 16'(res_valid), 16'd0);
    cmp("R1", "addr", res_addr, 16'h0);
    cmp("R1", "sp", res_sp, 16'h0);
    cmp("R1", "lit", res_lit, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      set_pat(p);
      for (int c = 0; c < 64; c++) apply(6'(c));
      // R10 hold with enable low
      h_addr = res_addr; h_sp = res_sp; h_pc = res_pc; h_lit = res_lit;
      code = 6'h1a; sp_cur = sp_cur ^ 16'h5555; pc_cur = pc_cur ^ 16'h0F0F;
      @(negedge clk);
      cmp("R10", "idle valid", 16'(res_valid), 16'd0);
      cmp("R10", "hold addr", res_addr, h_addr);
      cmp("R10", "hold sp", res_sp, h_sp);
      cmp("R10", "hold pc", res_pc, h_pc);
      cmp("R10", "hold lit", res_lit, h_lit);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule